// File: doc/BRIEF.md
# Modem Status Change Interrupt

This block watches two active-low handshake lines from a modem, clear-to-send and data-set-ready. Each line is brought into the clock domain through a synchroniser. The block shows the lines to software as an 8-bit status image in positive logic, so a 1 always means "asserted".

Any level change on either line, rising or falling, sets a sticky change flag. The flag stays set until software reads the status image, which it reports with a one-cycle read strobe. An interrupt output is raised while the flag is set, but only when both the modem interrupt enable and the global interrupt enable are high.

A change that arrives in the same cycle as the clearing read is not lost. The flag stays set for that change.

Top module: `modem_chg_irq`

## Requirements
- R1: After reset, and immediately on asserting reset, the status image reads 0x00, the change flag is 0 and the interrupt is 0.
- R2: The status image is inverted from the pins. Bit 0 is 1 while the clear-to-send pin is low. Bit 1 is 1 while the data-set-ready pin is low. A pin change reaches the image at the second rising clock edge after it.
- R3: Bits 7 to 2 of the status image always read 0.
- R4: Any change of either pin, in either direction, sets the change flag at the third rising edge after the pin change. The flag is still 0 after the second edge.
- R5: Once set, the change flag holds until a cycle with the read strobe high. It is then 0 after that clock edge, provided no new change is pending.
- R6: A change detected in the same cycle as the read strobe leaves the change flag set after that edge.
- R7: The interrupt output equals the change flag AND the modem interrupt enable AND the global interrupt enable. It responds to the enables within the same cycle.
- R8: A read strobe while the flag is clear and no change is pending leaves the flag at 0 and the interrupt at 0.
- R9: Reading does not alter the status image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_i | input | 1 | Data-set-ready pin, active low, asynchronous |
| stat_rd_i | input | 1 | One-cycle strobe marking a read of the status image |
| mien_i | input | 1 | Modem interrupt enable |
| gien_i | input | 1 | Global interrupt enable |
| mstat_o | output | 8 | Status image: bit 0 clear-to-send, bit 1 data-set-ready, rest zero |
| chg_flag_o | output | 1 | Sticky modem status change flag |
| irq_o | output | 1 | Gated interrupt request |

## Verification
On every cycle, the embedded assertions check the change flag's register behaviour against the detected-change signal and the read strobe. They cover three things: a detected change sets the flag, the flag holds without a read, and a read clears it. They also check that the flag never rises without a detected change.

Other properties only the bench scenarios can show:
- the exact edge counts from pin to image and from pin to flag;
- the inversion and bit placement of the image;
- the case of a read landing on a change;
- that stray reads leave both flag and image untouched.

// File: rtl/mchg_pkg.sv
package mchg_pkg;
  localparam int unsigned N_LINES  = 2;
  localparam int unsigned LN_CTS   = 0;
  localparam int unsigned LN_DSR   = 1;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned SYNC_DEF = 2;
endpackage

// File: rtl/mchg_rst_sync.sv
module mchg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/mchg_sync.sv
module mchg_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o
);
  // Idle level of active-low pins is 1: reset the chain there so that
  // leaving reset with idle pins produces no change event.
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = pin_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_comb begin
      stg_d[s] = stg_q[s-1];
    end
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '1;
      else        stg_q[s] <= stg_d[s];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/mchg_edge.sv
module mchg_edge #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic             any_chg_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;
  logic [WIDTH-1:0] diff;

  always_comb begin
    prev_d = lvl_i;
    diff   = lvl_i ^ prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= prev_d;
  end

  assign any_chg_o = |diff;
endmodule

// File: rtl/mchg_flag.sv
module mchg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;

  // Set wins over clear so a change coinciding with a read survives.
  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_CHG_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q); // R4 R6
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q); // R5
  AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !set_i) |=> !flag_q); // R8
endmodule

// File: rtl/modem_chg_irq.sv
module modem_chg_irq
  import mchg_pkg::*;
#(
  parameter int unsigned STAT_BITS   = STAT_W,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cts_n_i,
  input  logic                 dsr_n_i,
  input  logic                 stat_rd_i,
  input  logic                 mien_i,
  input  logic                 gien_i,
  output logic [STAT_BITS-1:0] mstat_o,
  output logic                 chg_flag_o,
  output logic                 irq_o
);
  logic               srst_n;
  logic [N_LINES-1:0] pins_n;
  logic [N_LINES-1:0] sync_n;
  logic               any_chg;
  logic               flag;

  always_comb begin
    pins_n         = '1;
    pins_n[LN_CTS] = cts_n_i;
    pins_n[LN_DSR] = dsr_n_i;
  end

  mchg_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  mchg_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (srst_n),
    .pin_i  (pins_n),
    .sync_o (sync_n)
  );

  mchg_edge #(.WIDTH(N_LINES)) u_edge (
    .clk       (clk),
    .rst_n     (srst_n),
    .lvl_i     (sync_n),
    .any_chg_o (any_chg)
  );

  mchg_flag u_flag (
    .clk    (clk),
    .rst_n  (srst_n),
    .set_i  (any_chg),
    .clr_i  (stat_rd_i),
    .flag_o (flag)
  );

  always_comb begin
    mstat_o              = '0;
    mstat_o[N_LINES-1:0] = ~sync_n;
  end

  assign chg_flag_o = flag;
  assign irq_o      = flag & mien_i & gien_i;
endmodule

// File: tb/sim_modem_chg_irq.sv
module sim_modem_chg_irq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cts_n, dsr_n, rd, mien, gien;
  logic [7:0] mstat;
  logic       flag, irq;
  int         checks = 0;
  int         errors = 0;
  bit         done   = 1'b0;

  always #4 clk = ~clk;

  modem_chg_irq u0 (
    .clk(clk), .rst_n(rst_n), .cts_n_i(cts_n), .dsr_n_i(dsr_n),
    .stat_rd_i(rd), .mien_i(mien), .gien_i(gien),
    .mstat_o(mstat), .chg_flag_o(flag), .irq_o(irq)
  );

  // [8]cts_n [7]dsr_n [6]mien [5]gien [4]read [3:2]exp image [1]exp flag [0]exp irq
  localparam logic [8:0] VEC [7] = '{
    9'b1_1_1_1_0_00_0_0,
    9'b0_1_1_1_1_01_1_1,
    9'b0_0_1_0_1_11_1_0,
    9'b1_0_0_1_0_10_1_0,
    9'b1_0_1_1_1_10_1_1,
    9'b1_1_1_1_1_00_1_1,
    9'b1_1_1_1_0_00_0_0
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_pulse();
    rd = 1'b1;
    cyc(1);
    rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cts_n = 1'b1; dsr_n = 1'b1; rd = 1'b0; mien = 1'b1; gien = 1'b1;
    cyc(3);
    chk("R1 image in reset", mstat, 8'h00);
    chk("R1 flag in reset", {7'd0, flag}, 8'd0);
    chk("R1 irq in reset", {7'd0, irq}, 8'd0);
    rst_n = 1'b1;
    cyc(5);
    chk("R1 image after reset", mstat, 8'h00);
    chk("R1 flag after reset", {7'd0, flag}, 8'd0);

    for (int i = 0; i < 7; i++) begin
      cts_n = VEC[i][8]; dsr_n = VEC[i][7]; mien = VEC[i][6]; gien = VEC[i][5];
      cyc(4);
      chk("R2 R3 image", mstat, {6'd0, VEC[i][3:2]});
      chk("R4 R5 flag", {7'd0, flag}, {7'd0, VEC[i][1]});
      chk("R7 irq", {7'd0, irq}, {7'd0, VEC[i][0]});
      if (VEC[i][4]) begin
        read_pulse();
        chk("R5 cleared by read", {7'd0, flag}, 8'd0);
        chk("R9 image kept on read", mstat, {6'd0, VEC[i][3:2]});
      end
    end

    // R4 / R2 timing: pins now idle, flag clear
    mien = 1'b1; gien = 1'b1;
    cts_n = 1'b0;
    cyc(1);
    chk("R2 image not yet after one edge", mstat, 8'h00);
    cyc(1);
    chk("R2 image after two edges", mstat, 8'h01);
    chk("R4 flag still clear after two edges", {7'd0, flag}, 8'd0);
    cyc(1);
    chk("R4 flag set after three edges", {7'd0, flag}, 8'd1);

    // R6: read lands in the cycle the next change is detected
    cts_n = 1'b1;
    cyc(2);
    rd = 1'b1;
    cyc(1);
    rd = 1'b0;
    chk("R6 flag survives coincident read", {7'd0, flag}, 8'd1);
    read_pulse();
    chk("R5 flag cleared by later read", {7'd0, flag}, 8'd0);

    // R8: stray read with nothing pending
    cyc(2);
    read_pulse();
    chk("R8 flag stays clear", {7'd0, flag}, 8'd0);
    chk("R8 irq stays low", {7'd0, irq}, 8'd0);
    chk("R9 image unchanged by stray read", mstat, 8'h00);

    // R7: enables gate combinationally
    dsr_n = 1'b0; gien = 1'b0;
    cyc(4);
    chk("R7 irq blocked by global enable", {7'd0, irq}, 8'd0);
    gien = 1'b1;
    #1;
    chk("R7 irq follows global enable", {7'd0, irq}, 8'd1);
    mien = 1'b0;
    #1;
    chk("R7 irq blocked by modem enable", {7'd0, irq}, 8'd0);
    mien = 1'b1;

    // R1: asynchronous reset clears at once
    cyc(1);
    rst_n = 1'b0;
    #1;
    chk("R1 flag cleared by async reset", {7'd0, flag}, 8'd0);
    chk("R1 irq cleared by async reset", {7'd0, irq}, 8'd0);
    chk("R1 image cleared by async reset", mstat, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule